// File: doc/BRIEF.md
# Two-Level Interrupt Controller

This block gathers level-sensitive interrupt requests from a set of peripheral and external sources. It turns them into two request lines for a processor: a normal request (`irq_o`) and a fast request (`fiq_o`). Each source is first brought into the clock domain by a two-flop synchronizer. The synchronized levels form a raw view that is shared by both request levels. Each level has its own enable mask. A source is routed to a level by enabling it there. Within a level, sources have no priority: any enabled pending source raises the line.

Software reaches the block over a small synchronous register bus. Writes take effect on the clock edge and reads are combinational. The enable masks use separate set and clear addresses, so software never has to read, modify and write. A force register lets software raise either request line directly, whether or not any source is enabled. The block does not clear requests at the peripheral; it only mirrors the source levels.

Top module: `dual_level_intc`

## Requirements
- R1: The raw register of each level reads the source levels as they were two clock edges earlier, whatever the enable masks hold.
- R2: Writing a word to a level's enable-set address (IRQ 0x1, FIQ 0x5) sets each enable bit whose written bit is 1. Bits written as 0 keep their value. The enable register reads back at the same address.
- R3: Writing a word to a level's enable-clear address (IRQ 0x3, FIQ 0x7) clears each enable bit whose written bit is 1. Bits written as 0 keep their value. The raw register does not change.
- R4: A level's status register (IRQ 0x2, FIQ 0x6) reads as that level's raw bits ANDed with its enable bits. The raw registers are at IRQ 0x0 and FIQ 0x4.
- R5: Each request output is a register. It is 1 one edge after any of its level's status bits is 1 or its force bit is 1, and 0 otherwise. The two levels are independent of each other.
- R6: The force register at 0x8 holds the IRQ force in bit 0 and the FIQ force in bit 1, and it reads back. Forcing raises the line even when all enables are 0.
- R7: After reset, both enable registers and both force bits are 0, and both request outputs are low.
- R8: Enable-clear addresses, unmapped addresses (0x9 to 0xF) and unused upper data bits read as 0. Writes to raw and status addresses change no state.
- R9: A source that rises while it is enabled raises its request output on the third clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NSRC | Level request from each source |
| bus_addr_i | input | 4 | Register word address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data for the current address |
| irq_o | output | 1 | Normal request to the processor |
| fiq_o | output | 1 | Fast request to the processor |

## Verification
The hardest case to reach is a pending source whose enable is changed by the set or clear addresses while other sources stay in place. The check must show that only the written bits move and that the raw view stays put. The bench gets there by sweeping all 256 source patterns under several enable patterns on each level. It then applies single-bit set and clear writes on top of a live source pattern, reading the enable, raw and status registers and both lines after each write. Three-edge latency and forcing with every enable at 0 are driven as separate sequences.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int ADDR_W  = 4;
    localparam int NUM_LVL = 2;
    localparam int LVL_IRQ = 0;
    localparam int LVL_FIQ = 1;

    // Address layout: bit 3 = force register, bit 2 = level, bits 1:0 = register kind
    typedef enum logic [1:0] {
        K_RAW  = 2'd0,
        K_EN   = 2'd1,
        K_STAT = 2'd2,
        K_CLR  = 2'd3
    } reg_kind_e;

    localparam logic [ADDR_W-1:0] ADDR_FORCE = 4'h8;

    function automatic logic [ADDR_W-1:0] lvl_addr(input logic lvl, input reg_kind_e k);
        return {1'b0, lvl, k};
    endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = d_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign q_o = s_q.stable;
endmodule

// File: rtl/intc_level.sv
module intc_level #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] raw_i,
    input  logic         set_we_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] wmask_i,
    input  logic         force_i,
    output logic [N-1:0] en_o,
    output logic [N-1:0] stat_o,
    output logic         req_o
);
    typedef struct packed {
        logic [N-1:0] en;
        logic         req;
    } lvl_t;

    lvl_t s_d, s_q;
    logic [N-1:0] stat_w;

    assign stat_w = raw_i & s_q.en;

    always_comb begin
        s_d = s_q;
        if (set_we_i) s_d.en = s_q.en | wmask_i;
        if (clr_we_i) s_d.en = s_q.en & ~wmask_i;
        s_d.req = (|stat_w) | force_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign en_o   = s_q.en;
    assign stat_o = stat_w;
    assign req_o  = s_q.req;
endmodule

// File: rtl/dual_level_intc.sv
module dual_level_intc
    import intc_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int DW   = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NSRC-1:0]      src_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic                 bus_we_i,
    input  logic [DW-1:0]        bus_wdata_i,
    output logic [DW-1:0]        bus_rdata_o,
    output logic                 irq_o,
    output logic                 fiq_o
);
    localparam int PAD = DW - NSRC;

    typedef struct packed {
        logic fiq_f;
        logic irq_f;
    } frc_t;

    frc_t f_d, f_q;

    logic [NSRC-1:0] raw_w;
    logic [NSRC-1:0] en_w   [NUM_LVL];
    logic [NSRC-1:0] stat_w [NUM_LVL];
    logic [NUM_LVL-1:0] req_w;
    logic [NUM_LVL-1:0] frc_w;

    logic [NSRC-1:0] irq_raw, irq_en, irq_stat;
    logic [NSRC-1:0] fiq_raw, fiq_en, fiq_stat;

    intc_sync #(.W(NSRC)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (src_i),
        .q_o   (raw_w)
    );

    assign frc_w[LVL_IRQ] = f_q.irq_f;
    assign frc_w[LVL_FIQ] = f_q.fiq_f;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        localparam logic LB = 1'(l);
        logic set_we, clr_we;
        assign set_we = bus_we_i && (bus_addr_i == lvl_addr(LB, K_EN));
        assign clr_we = bus_we_i && (bus_addr_i == lvl_addr(LB, K_CLR));

        intc_level #(.N(NSRC)) u_level (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .raw_i   (raw_w),
            .set_we_i(set_we),
            .clr_we_i(clr_we),
            .wmask_i (bus_wdata_i[NSRC-1:0]),
            .force_i (frc_w[l]),
            .en_o    (en_w[l]),
            .stat_o  (stat_w[l]),
            .req_o   (req_w[l])
        );
    end

    assign irq_raw  = raw_w;
    assign fiq_raw  = raw_w;
    assign irq_en   = en_w[LVL_IRQ];
    assign fiq_en   = en_w[LVL_FIQ];
    assign irq_stat = stat_w[LVL_IRQ];
    assign fiq_stat = stat_w[LVL_FIQ];

    always_comb begin
        f_d = f_q;
        if (bus_we_i && bus_addr_i == ADDR_FORCE) begin
            f_d.irq_f = bus_wdata_i[0];
            f_d.fiq_f = bus_wdata_i[1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) f_q <= '0;
        else         f_q <= f_d;
    end

    always_comb begin
        logic [NSRC-1:0] sel;
        sel = '0;
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_FORCE) begin
            bus_rdata_o[1:0] = {f_q.fiq_f, f_q.irq_f};
        end else if (!bus_addr_i[3]) begin
            unique case (reg_kind_e'(bus_addr_i[1:0]))
                K_RAW:  sel = bus_addr_i[2] ? fiq_raw  : irq_raw;
                K_EN:   sel = bus_addr_i[2] ? fiq_en   : irq_en;
                K_STAT: sel = bus_addr_i[2] ? fiq_stat : irq_stat;
                default: sel = '0;
            endcase
            bus_rdata_o = {{PAD{1'b0}}, sel};
        end
    end

    assign irq_o = req_w[LVL_IRQ];
    assign fiq_o = req_w[LVL_FIQ];
endmodule

module intc_chk
    import intc_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int DW   = 32
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NSRC-1:0]      src_i,
    input logic [ADDR_W-1:0]    bus_addr_i,
    input logic                 bus_we_i,
    input logic [DW-1:0]        bus_wdata_i,
    input logic                 irq_o,
    input logic                 fiq_o,
    input logic [NSRC-1:0]      irq_raw,
    input logic [NSRC-1:0]      irq_en,
    input logic [NSRC-1:0]      fiq_en,
    input logic [NSRC-1:0]      irq_stat,
    input logic [NSRC-1:0]      fiq_stat,
    input logic                 frc_irq,
    input logic                 frc_fiq
);
    logic [1:0] age_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R1
    raw_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd2) |-> (irq_raw == $past(src_i, 2)));

    // R2
    en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == 4'h1) |=>
        ((irq_en & $past(bus_wdata_i[NSRC-1:0])) == $past(bus_wdata_i[NSRC-1:0])));

    // R3
    en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == 4'h7) |=>
        ((fiq_en & $past(bus_wdata_i[NSRC-1:0])) == '0));

    // R5
    irq_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|irq_stat) || frc_irq) |=> irq_o);

    // R5
    fiq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(|fiq_stat) && !frc_fiq) |=> !fiq_o);

    // R7
    reset_state_chk: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (!irq_o && !fiq_o && irq_en == '0 && fiq_en == '0));
endmodule

bind dual_level_intc intc_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .bus_addr_i (bus_addr_i),
    .bus_we_i   (bus_we_i),
    .bus_wdata_i(bus_wdata_i),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o),
    .irq_raw    (irq_raw),
    .irq_en     (irq_en),
    .fiq_en     (fiq_en),
    .irq_stat   (irq_stat),
    .fiq_stat   (fiq_stat),
    .frc_irq    (f_q.irq_f),
    .frc_fiq    (f_q.fiq_f)
);

// File: tb/dual_level_intc_tb.sv
module dual_level_intc_tb;
    localparam int NSRC = 8;
    localparam int DW   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic [3:0]      addr = '0;
    logic            we = 1'b0;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic            irq, fiq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dual_level_intc #(.NSRC(NSRC), .DW(DW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src),
        .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
    );

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
        addr = a; wdata = d; we = 1'b1;
        cyc();
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    logic [DW-1:0] v;
    logic [NSRC-1:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc();
        // R7 reset state
        chk("R7 irq", irq, 0);
        chk("R7 fiq", fiq, 0);
        rd(4'h1, v); chk("R7 irq_en", v, 0);
        rd(4'h5, v); chk("R7 fiq_en", v, 0);
        rd(4'h8, v); chk("R7 force", v, 0);

        // R8 reads of clear and unmapped addresses
        wr(4'h1, 32'hFF); wr(4'h5, 32'hFF);
        rd(4'h3, v); chk("R8 irq_clr read", v, 0);
        rd(4'h7, v); chk("R8 fiq_clr read", v, 0);
        for (int a = 9; a < 16; a++) begin
            rd(4'(a), v); chk("R8 unmapped read", v, 0);
        end
        wr(4'h3, 32'hFF); wr(4'h7, 32'hFF);

        // R1 R4 R5 sweep over levels, enable patterns and all source patterns
        for (int lvl = 0; lvl < 2; lvl++) begin
            for (int p = 0; p < 4; p++) begin
                wr(lvl ? 4'h7 : 4'h3, 32'hFF);
                wr(lvl ? 4'h5 : 4'h1, {24'h0, pats[p]});
                for (int s = 0; s < 256; s++) begin
                    src = 8'(s);
                    cyc(3);
                    rd(lvl ? 4'h4 : 4'h0, v); chk("R1 raw", v, 32'(s));
                    rd(lvl ? 4'h6 : 4'h2, v); chk("R4 status", v, 32'(8'(s) & pats[p]));
                    chk("R5 own line", lvl ? fiq : irq, |(8'(s) & pats[p]));
                    chk("R5 other line", lvl ? irq : fiq, 0);
                end
                wr(lvl ? 4'h7 : 4'h3, 32'hFF);
            end
        end

        // R2 set without read-modify-write
        src = 8'h5A; cyc(3);
        wr(4'h1, 32'h01); wr(4'h1, 32'h10);
        rd(4'h1, v); chk("R2 accumulate", v, 32'h11);
        wr(4'h1, 32'hFFFF_FF00);
        rd(4'h1, v); chk("R2 zeros keep", v, 32'h11);
        rd(4'h2, v); chk("R4 status after set", v, 32'h10);
        cyc(); chk("R5 irq from set", irq, 1);

        // R3 clear masks only the written bits, raw untouched
        wr(4'h3, 32'h10);
        rd(4'h1, v); chk("R3 clear one", v, 32'h01);
        rd(4'h0, v); chk("R3 raw unchanged", v, 32'h5A);
        cyc(); chk("R3 irq masked", irq, 0);
        wr(4'h5, 32'h0A); wr(4'h7, 32'h02);
        rd(4'h5, v); chk("R3 fiq clear", v, 32'h08);
        cyc(); chk("R5 fiq from bit3", fiq, 1);

        // R8 writes to raw/status ignored
        wr(4'h0, 32'hFF); wr(4'h2, 32'hFF); wr(4'h4, 32'h00); wr(4'h6, 32'hFF);
        rd(4'h1, v); chk("R8 irq_en after ro writes", v, 32'h01);
        rd(4'h5, v); chk("R8 fiq_en after ro writes", v, 32'h08);
        rd(4'h4, v); chk("R8 raw after ro writes", v, 32'h5A);
        rd(4'h8, v); chk("R8 force after ro writes", v, 0);
        wr(4'h3, 32'hFF); wr(4'h7, 32'hFF);

        // R6 force bypasses enables
        src = 8'hFF; cyc(3);
        wr(4'h8, 32'h1);
        chk("R6 irq forced", irq, 0);
        cyc(); chk("R6 irq forced", irq, 1); chk("R6 fiq not forced", fiq, 0);
        rd(4'h8, v); chk("R6 readback", v, 32'h1);
        wr(4'h8, 32'h2); cyc();
        chk("R6 fiq forced", fiq, 1); chk("R6 irq released", irq, 0);
        wr(4'h8, 32'h3); cyc();
        chk("R6 both", {fiq, irq}, 2'b11);
        wr(4'h8, 32'h0); cyc();
        chk("R6 none", {fiq, irq}, 2'b00);

        // R9 latency of three edges
        src = 8'h00; cyc(3);
        wr(4'h1, 32'h04);
        cyc();
        src = 8'h04;
        cyc(2); chk("R9 not yet", irq, 0);
        cyc();  chk("R9 raised", irq, 1);
        src = 8'h00;
        cyc(2); chk("R9 still high", irq, 1);
        cyc();  chk("R9 dropped", irq, 0);

        // R7 reset again clears state
        wr(4'h8, 32'h3); wr(4'h5, 32'hFF);
        rst_n = 1'b0; #1;
        chk("R7 async irq", irq, 0);
        rd(4'h5, v); chk("R7 async fiq_en", v, 0);
        cyc(); rst_n = 1'b1; cyc();
        rd(4'h8, v); chk("R7 force after reset", v, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule